// File: doc/BRIEF.md
# Byte-Wide EEPROM Access and Burst Loader

This block lets a host read or write single bytes of an external byte-wide EEPROM, and stream EEPROM contents into on-chip memory. The EEPROM appears as a byte request/response port: the block raises a request with an address, an optional write byte and a write flag, and the port answers with a one-cycle done pulse, which carries read data on reads. The host uses a small word-indexed register file. It holds a command register, an EEPROM address register, a byte data register, a memory base register and a burst-start register.

A single access begins when a request bit is written to the command register. That bit reads back as 1 until the access completes. In burst mode the engine reads records of three bytes from consecutive EEPROM locations. Each record holds a low address byte, then a high address byte, then a data byte. The engine writes the data byte to a 24-bit memory address. Bits [23:15] of that address come from the base register. The lower 15 bits come from the record address, and bit 15 of the record address is dropped. A record address of 0xFFFF ends the burst.

Top module: `eeprom_burst_ctrl`

## Requirements
- R1: After reset all registers read 0, the busy flag is 0, and neither an EEPROM request nor a memory write strobe is active.
- R2: Writing the command register (index 0) with bit 0 set and bit 1 clear performs one EEPROM write. The byte in the data register (index 2) goes to the location in the address register (index 1), and bit 0 reads 1 until the write completes.
- R3: Writing the command register with bit 1 set performs one EEPROM read of the location in the address register. The byte is loaded into the data register, and command bit 1 reads 1 until the data is valid.
- R4: If bits 0 and 1 are both set in one command write, only the read is performed.
- R5: An EEPROM request is held with a stable address, write flag and write byte until done is reported. After done the request drops for at least one cycle before the next request.
- R6: Command bit 2 reads 1 from an accepted command until the operation ends. Host writes to any register while busy are ignored.
- R7: Writing bit 0 of the burst register (index 4) starts a burst. That bit reads 1 while the burst runs and clears itself at the end.
- R8: A burst started after reset, before any single access, reads from EEPROM address 0 upward.
- R9: Otherwise a burst begins at the EEPROM address after the last byte accessed, whether that byte was accessed singly or in a burst.
- R10: A burst record is a low address byte, a high address byte and a data byte. A record address of 0xFFFF ends the burst without a memory write.
- R11: Each record produces a one-cycle memory write strobe. The strobe carries the data byte and the address {base[8:0], record address[14:0]}, where the base register is index 3 and record address bit 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register index |
| reg_wdata_i | input | 16 | Host write data |
| reg_rdata_o | output | 16 | Read-back of the indexed register |
| eep_req_o | output | 1 | EEPROM request, held until done |
| eep_we_o | output | 1 | Request is a write |
| eep_addr_o | output | 16 | EEPROM byte address |
| eep_wdata_o | output | 8 | Byte to write |
| eep_rdata_i | input | 8 | Byte read, valid with done |
| eep_done_i | input | 1 | One-cycle completion pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 24 | Memory write address |
| mem_data_o | output | 8 | Memory write byte |

## Verification
The assertions check on every cycle that the request handshake holds, that no request is raised while idle, and that write strobes are single pulses whose upper address bits equal the base register. Other behaviours can only be shown by the bench's scenarios. These are where a burst begins after reset and after earlier accesses, the record decoding and end marker, the loss of record address bit 15, read priority over write, and the dropping of host writes during busy periods.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SINGLE, ST_LO, ST_HI, ST_DAT
  } eng_st_e;

  localparam logic [2:0] IDX_CMD   = 3'd0;
  localparam logic [2:0] IDX_ADDR  = 3'd1;
  localparam logic [2:0] IDX_DATA  = 3'd2;
  localparam logic [2:0] IDX_BASE  = 3'd3;
  localparam logic [2:0] IDX_BURST = 3'd4;
endpackage

// File: rtl/eeb_regs.sv
module eeb_regs
  import eeb_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int BASE_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [EE_AW-1:0]  reg_wdata_i,
  output logic [EE_AW-1:0]  reg_rdata_o,
  input  logic              busy_i,
  input  logic              rd_pend_i,
  input  logic              wr_pend_i,
  input  logic              burst_i,
  input  logic              rd_valid_i,
  input  logic [7:0]        rd_byte_i,
  output logic              start_rd_o,
  output logic              start_wr_o,
  output logic              start_burst_o,
  output logic [EE_AW-1:0]  addr_o,
  output logic [7:0]        data_o,
  output logic [BASE_W-1:0] base_o
);
  logic wr_ok;
  assign wr_ok = reg_we_i && !busy_i;

  // read wins when both request bits are set
  assign start_rd_o    = wr_ok && (reg_addr_i == IDX_CMD) && reg_wdata_i[1];
  assign start_wr_o    = wr_ok && (reg_addr_i == IDX_CMD) && reg_wdata_i[0] && !reg_wdata_i[1];
  assign start_burst_o = wr_ok && (reg_addr_i == IDX_BURST) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      base_o <= '0;
    end else begin
      if (wr_ok && reg_addr_i == IDX_ADDR) addr_o <= reg_wdata_i;
      if (wr_ok && reg_addr_i == IDX_BASE) base_o <= reg_wdata_i[BASE_W-1:0];
      if (rd_valid_i)                          data_o <= rd_byte_i;
      else if (wr_ok && reg_addr_i == IDX_DATA) data_o <= reg_wdata_i[7:0];
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      IDX_CMD:   reg_rdata_o[2:0] = {busy_i, rd_pend_i, wr_pend_i};
      IDX_ADDR:  reg_rdata_o = addr_o;
      IDX_DATA:  reg_rdata_o[7:0] = data_o;
      IDX_BASE:  reg_rdata_o[BASE_W-1:0] = base_o;
      IDX_BURST: reg_rdata_o[0] = burst_i;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/eeb_engine.sv
module eeb_engine
  import eeb_pkg::*;
#(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int LOW_W  = 15
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_rd_i,
  input  logic                     start_wr_i,
  input  logic                     start_burst_i,
  input  logic [EE_AW-1:0]         addr_i,
  input  logic [7:0]               wdata_i,
  input  logic [MEM_AW-LOW_W-1:0]  base_i,
  output logic                     busy_o,
  output logic                     rd_pend_o,
  output logic                     wr_pend_o,
  output logic                     burst_o,
  output logic                     rd_valid_o,
  output logic [7:0]               rd_byte_o,
  output logic                     eep_req_o,
  output logic                     eep_we_o,
  output logic [EE_AW-1:0]         eep_addr_o,
  output logic [7:0]               eep_wdata_o,
  input  logic [7:0]               eep_rdata_i,
  input  logic                     eep_done_i,
  output logic                     mem_we_o,
  output logic [MEM_AW-1:0]        mem_addr_o,
  output logic [7:0]               mem_data_o
);
  localparam int HI_KEEP = LOW_W - 8;

  eng_st_e              st_q;
  logic                 req_q, we_q;
  logic [EE_AW-1:0]     op_addr_q, nxt_ptr_q;
  logic [7:0]           wdata_q, lo_q;
  logic [HI_KEEP-1:0]   hi_q;

  assign busy_o      = (st_q != ST_IDLE);
  assign rd_pend_o   = (st_q == ST_SINGLE) && !we_q;
  assign wr_pend_o   = (st_q == ST_SINGLE) && we_q;
  assign burst_o     = (st_q == ST_LO) || (st_q == ST_HI) || (st_q == ST_DAT);
  assign rd_valid_o  = (st_q == ST_SINGLE) && !we_q && req_q && eep_done_i;
  assign rd_byte_o   = eep_rdata_i;
  assign eep_req_o   = req_q;
  assign eep_we_o    = we_q;
  assign eep_addr_o  = op_addr_q;
  assign eep_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      req_q      <= 1'b0;
      we_q       <= 1'b0;
      op_addr_q  <= '0;
      nxt_ptr_q  <= '0;
      wdata_q    <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_rd_i || start_wr_i) begin
          st_q      <= ST_SINGLE;
          op_addr_q <= addr_i;
          we_q      <= start_wr_i;
          wdata_q   <= wdata_i;
          req_q     <= 1'b1;
        end else if (start_burst_i) begin
          st_q      <= ST_LO;
          op_addr_q <= nxt_ptr_q;
          we_q      <= 1'b0;
          req_q     <= 1'b1;
        end
      end else if (!req_q) begin
        // gap cycle between burst bytes
        req_q     <= 1'b1;
        op_addr_q <= nxt_ptr_q;
      end else if (eep_done_i) begin
        req_q     <= 1'b0;
        nxt_ptr_q <= op_addr_q + 1'b1;
        unique case (st_q)
          ST_SINGLE: st_q <= ST_IDLE;
          ST_LO: begin
            lo_q <= eep_rdata_i;
            st_q <= ST_HI;
          end
          ST_HI: begin
            if ({eep_rdata_i, lo_q} == 16'hFFFF) st_q <= ST_IDLE;
            else begin
              hi_q <= eep_rdata_i[HI_KEEP-1:0];
              st_q <= ST_DAT;
            end
          end
          ST_DAT: begin
            mem_we_o   <= 1'b1;
            mem_addr_o <= {base_i, hi_q, lo_q};
            mem_data_o <= eep_rdata_i;
            st_q       <= ST_LO;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eep_req_o && !eep_done_i |=> eep_req_o && $stable(eep_addr_o) && $stable(eep_we_o) && $stable(eep_wdata_o));
  p_req_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eep_req_o && eep_done_i |=> !eep_req_o);
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !eep_req_o);
  p_mem_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);
endmodule

// File: rtl/eeprom_burst_ctrl.sv
module eeprom_burst_ctrl #(
  parameter int EE_AW  = 16,
  parameter int MEM_AW = 24,
  parameter int LOW_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [EE_AW-1:0]  reg_wdata_i,
  output logic [EE_AW-1:0]  reg_rdata_o,
  output logic              eep_req_o,
  output logic              eep_we_o,
  output logic [EE_AW-1:0]  eep_addr_o,
  output logic [7:0]        eep_wdata_o,
  input  logic [7:0]        eep_rdata_i,
  input  logic              eep_done_i,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o
);
  localparam int BASE_W = MEM_AW - LOW_W;

  logic busy, rd_pend, wr_pend, burst, rd_valid;
  logic start_rd, start_wr, start_burst;
  logic [7:0] rd_byte, data_q;
  logic [EE_AW-1:0] addr_q;
  logic [BASE_W-1:0] base_q;

  eeb_regs #(.EE_AW(EE_AW), .BASE_W(BASE_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .rd_pend_i(rd_pend), .wr_pend_i(wr_pend), .burst_i(burst),
    .rd_valid_i(rd_valid), .rd_byte_i(rd_byte),
    .start_rd_o(start_rd), .start_wr_o(start_wr), .start_burst_o(start_burst),
    .addr_o(addr_q), .data_o(data_q), .base_o(base_q)
  );

  eeb_engine #(.EE_AW(EE_AW), .MEM_AW(MEM_AW), .LOW_W(LOW_W)) u_engine (
    .clk_i, .rst_ni,
    .start_rd_i(start_rd), .start_wr_i(start_wr), .start_burst_i(start_burst),
    .addr_i(addr_q), .wdata_i(data_q), .base_i(base_q),
    .busy_o(busy), .rd_pend_o(rd_pend), .wr_pend_o(wr_pend), .burst_o(burst),
    .rd_valid_o(rd_valid), .rd_byte_o(rd_byte),
    .eep_req_o, .eep_we_o, .eep_addr_o, .eep_wdata_o, .eep_rdata_i, .eep_done_i,
    .mem_we_o, .mem_addr_o, .mem_data_o
  );

  p_mem_base_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o[MEM_AW-1:LOW_W] == base_q);
  p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && reg_we_i && reg_addr_i == 3'd3 |=> $stable(base_q));
endmodule

// File: tb/eeprom_burst_ctrl_test.sv
module eeprom_burst_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic eep_req, eep_we, eep_done = 0;
  logic [15:0] eep_addr;
  logic [7:0] eep_wdata, eep_rdata = 0;
  logic mem_we;
  logic [23:0] mem_addr;
  logic [7:0] mem_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] ee_mem [256];
  int lat_cnt = 0;
  int log_n = 0;
  logic [23:0] log_a [4];
  logic [7:0]  log_d [4];

  always #5 clk = ~clk;

  eeprom_burst_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eep_req_o(eep_req), .eep_we_o(eep_we), .eep_addr_o(eep_addr),
    .eep_wdata_o(eep_wdata), .eep_rdata_i(eep_rdata), .eep_done_i(eep_done),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data)
  );

  // EEPROM model: done after 3 waiting cycles
  always @(posedge clk) begin
    if (eep_done) eep_done <= 0;
    else if (eep_req) begin
      if (lat_cnt == 3) begin
        eep_done <= 1;
        lat_cnt <= 0;
        if (eep_we) ee_mem[eep_addr[7:0]] <= eep_wdata;
        else eep_rdata <= ee_mem[eep_addr[7:0]];
      end else lat_cnt <= lat_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we && log_n < 4) begin
      log_a[log_n] <= mem_addr;
      log_d[log_n] <= mem_data;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(string tag);
    logic [15:0] v;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      rd(3'd0, v);
      if (!v[2]) return;
    end
    chk({tag, " idle timeout"}, 1, 0);
  endtask

  localparam logic [23:0] VEC [6] = '{
    {16'h0010, 8'h3C}, {16'h0011, 8'h00}, {16'h0012, 8'hFF},
    {16'h0020, 8'hA5}, {16'h00FE, 8'h5A}, {16'h0013, 8'h81}
  };

  initial begin
    for (int i = 0; i < 256; i++) ee_mem[i] = 8'h00;
    // fresh burst records at 0
    ee_mem[0] = 8'h34; ee_mem[1] = 8'h92; ee_mem[2] = 8'hAB;
    ee_mem[3] = 8'h01; ee_mem[4] = 8'h00; ee_mem[5] = 8'h5C;
    ee_mem[6] = 8'hFF; ee_mem[7] = 8'hFF;
    ee_mem[8'h50] = 8'h6D;
    ee_mem[8'h99] = 8'h42;
    ee_mem[8'h60] = 8'hC3;
    ee_mem[8'h61] = 8'h00; ee_mem[8'h62] = 8'h7F; ee_mem[8'h63] = 8'h77;
    ee_mem[8'h64] = 8'hFF; ee_mem[8'h65] = 8'hFF;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R1 cmd", v, 0);
    rd(3'd1, v); chk("R1 addr", v, 0);
    rd(3'd3, v); chk("R1 base", v, 0);
    chk("R1 req", eep_req, 0);
    chk("R1 mem_we", mem_we, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // fresh burst
    wr(3'd3, 16'h01A5);
    wr(3'd4, 16'h0001);
    rd(3'd4, v); chk("R7 burst active", v[0], 1);
    wait_idle("R7");
    rd(3'd4, v); chk("R7 self clear", v[0], 0);
    chk("R10 record count", log_n, 2);
    chk("R8 R11 first addr", log_a[0], 24'hD29234);
    chk("R11 first data", log_d[0], 8'hAB);
    chk("R10 second addr", log_a[1], 24'hD28001);
    chk("R10 second data", log_d[1], 8'h5C);

    // table of single write then read-back
    foreach (VEC[k]) begin
      wr(3'd1, VEC[k][23:8]);
      wr(3'd2, {8'h00, VEC[k][7:0]});
      wr(3'd0, 16'h0001);
      rd(3'd0, v); chk("R2 write pending", v[0], 1);
      wait_idle("R2");
      chk("R2 eeprom byte", ee_mem[VEC[k][15:8]], VEC[k][7:0]);
      wr(3'd2, 16'h00EE);
      wr(3'd0, 16'h0002);
      rd(3'd0, v); chk("R3 read pending", v[1], 1);
      wait_idle("R3");
      rd(3'd2, v); chk("R3 read data", v, {8'h00, VEC[k][7:0]});
    end

    // writes during busy ignored
    wr(3'd1, 16'h0050);
    wr(3'd0, 16'h0002);
    rd(3'd0, v); chk("R6 busy flag", v[2], 1);
    wr(3'd1, 16'h0099);
    wr(3'd0, 16'h0001);
    wait_idle("R6");
    rd(3'd2, v); chk("R6 data after busy", v, 16'h006D);
    rd(3'd1, v); chk("R6 addr unchanged", v, 16'h0050);
    chk("R6 no stray write", ee_mem[8'h99], 8'h42);

    // read wins over write
    wr(3'd1, 16'h0060);
    wr(3'd2, 16'h0011);
    wr(3'd0, 16'h0003);
    wait_idle("R4");
    rd(3'd2, v); chk("R4 read data", v, 16'h00C3);
    chk("R4 eeprom untouched", ee_mem[8'h60], 8'hC3);

    // resume after last access (0x60)
    wr(3'd3, 16'h0003);
    wr(3'd4, 16'h0001);
    wait_idle("R9");
    chk("R9 record count", log_n, 3);
    chk("R9 resume addr", log_a[2], 24'h01FF00);
    chk("R9 resume data", log_d[2], 8'h77);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule